// File: doc/BRIEF.md
# SAR ADC Timed Readout Controller

This block runs an 18-bit successive-approximation converter whose conversion-start line also serves as its chip select, and which gives no busy indication. At the start of each frame the controller raises the start line. It holds the line high for a fixed worst-case conversion time, covering a conversion that may take anywhere from 500 to 710 ns. It then drops the line, waits a setup interval, and clocks the result out one bit at a time, most significant bit first. The finished sample appears as a parallel word together with a single-cycle valid strobe. A new frame begins every frame period, which is 1 µs at the default settings.

Every interval is a parameter counted in system-clock cycles: conversion hold, setup delay, serial-clock period and high time, and frame period. At elaboration the design checks that the hold, the setup and all serial-clock periods fit inside one frame with at least one spare cycle. The defaults assume a 200 MHz system clock. They give a 710 ns hold, a 10 ns setup and a 66.7 MHz serial clock, which keeps the serial clock under its 70 MHz limit. The readout then ends 990 ns into the 1 µs frame. A longer frame period leaves the converter more time to acquire its input.

The controller is a five-state machine:
- IDLE moves to CONV when enable is high.
- CONV moves to SETUP after CONV_CYC cycles.
- SETUP moves to SHIFT after SETUP_CYC cycles.
- SHIFT moves to REST after NBITS complete serial-clock periods.
- REST waits for the last cycle of the frame. It then moves to CONV if enable is high, and to IDLE otherwise.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While synchronous reset is asserted, and in the cycle after it, the start line, the serial clock and the valid strobe are low. Reset also clears the sample word to zero.
- R2: When enable is high in IDLE, the start line rises in the next cycle and stays high for exactly CONV_CYC cycles (default 142).
- R3: After the start line falls, the serial clock stays low for exactly SETUP_CYC cycles (default 2) before its first rising edge.
- R4: While the start line is high, the serial clock is low. Each frame has exactly NBITS (18) serial-clock rising edges, spaced SCK_DIV cycles apart (default 3), and each high phase lasts SCK_HI cycles (default 1).
- R5: The controller captures the serial data input at the clock edge that ends the first cycle of each serial-clock high phase. The first capture is the most significant bit, which the converter presents after the start line falls. The converter moves to the next bit on each falling edge of the serial clock. The word holds the captures in order, with the first capture at bit NBITS-1.
- R6: The valid strobe is high for exactly one cycle, the cycle after the 18th capture. The sample word changes only in that cycle.
- R7: While enable stays high, successive rising edges of the start line are exactly FRAME_CYC cycles apart (default 200).
- R8: When enable goes low, the frame in progress completes and delivers its sample. After that the start line stays low and the serial clock stays idle until enable returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable, sampled at frame boundaries and in IDLE |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion start line, which also acts as chip select |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | NBITS | Last captured sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions check these properties on every cycle:
- the length of the conversion hold;
- the quiet serial clock while the start line is high;
- the count of serial-clock rising edges per sample;
- the single-cycle width of the valid strobe;
- the minimum spacing between frames;
- the quiet outputs after reset.

Some behaviour can only be shown by the bench's scenarios, which drive a modelled converter with known words:
- whether the bits land MSB-first in the right word;
- whether the setup gap has the exact length;
- whether disabling mid-frame still delivers the final sample and then stops;
- whether a reset during the shift phase leaves no stale sample behind.

// File: rtl/sar_rd_pkg.sv
`timescale 1ns/1ps
package sar_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SETUP,
        ST_SHIFT,
        ST_REST
    } sar_st_e;
endpackage

// File: rtl/sar_rd_frame_timer.sv
`timescale 1ns/1ps
module sar_rd_frame_timer #(
    parameter int FRAME_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic last_o
);
    localparam int FW = $clog2(FRAME_CYC);

    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt <= '0;
        end else if (last_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + FW'(1);
        end
    end

    assign last_o = run_i && (cnt == FW'(FRAME_CYC - 1));
endmodule

// File: rtl/sar_rd_sclk_gen.sv
`timescale 1ns/1ps
module sar_rd_sclk_gen #(
    parameter int NBITS  = 18,
    parameter int SCK_DIV = 3,
    parameter int SCK_HI  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic sclk_o,
    output logic cap_o,
    output logic last_cap_o,
    output logic done_o
);
    localparam int PW = $clog2(SCK_DIV);
    localparam int BW = $clog2(NBITS);

    logic [PW-1:0] phase;
    logic [BW-1:0] bitn;
    logic          period_end;
    logic          final_bit;

    assign period_end = (phase == PW'(SCK_DIV - 1));
    assign final_bit  = (bitn == BW'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            phase <= '0;
            bitn  <= '0;
        end else if (period_end) begin
            phase <= '0;
            bitn  <= bitn + BW'(1);
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign sclk_o     = active_i && (phase < PW'(SCK_HI));
    assign cap_o      = active_i && (phase == '0);
    assign last_cap_o = cap_o && final_bit;
    assign done_o     = active_i && period_end && final_bit;
endmodule

// File: rtl/sar_rd_capture.sv
`timescale 1ns/1ps
module sar_rd_capture #(
    parameter int NBITS = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_i,
    input  logic             last_i,
    input  logic             sdo_i,
    output logic [NBITS-1:0] data_o,
    output logic             valid_o
);
    logic [NBITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap_i) begin
                sr <= {sr[NBITS-2:0], sdo_i};
            end
            if (last_i) begin
                data_o  <= {sr[NBITS-2:0], sdo_i};
                valid_o <= 1'b1;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R6
endmodule

// File: rtl/sar_rd_ctrl.sv
`timescale 1ns/1ps
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int NBITS     = 18,
    parameter int CONV_CYC  = 142,
    parameter int SETUP_CYC = 2,
    parameter int SCK_DIV   = 3,
    parameter int SCK_HI    = 1,
    parameter int FRAME_CYC = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             sdo_i,
    output logic             cnv_o,
    output logic             sclk_o,
    output logic [NBITS-1:0] data_o,
    output logic             valid_o
);
    localparam int DLY_MAX = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
    localparam int DW      = $clog2(DLY_MAX + 1);
    localparam int FIT_CYC = CONV_CYC + SETUP_CYC + NBITS * SCK_DIV;
    localparam int CW      = $clog2(FRAME_CYC + 2);
    localparam int RW      = $clog2(NBITS + 2);

    if (FIT_CYC >= FRAME_CYC || SCK_HI < 1 || SCK_HI >= SCK_DIV
        || SETUP_CYC < 1 || CONV_CYC < 1 || NBITS < 2) begin : g_fit_bad
        $error("sar_rd_ctrl: timing parameters do not fit in one frame");
    end

    sar_st_e       state;
    sar_st_e       state_n;
    logic [DW-1:0] dly;
    logic          frame_last;
    logic          shift_on;
    logic          cap;
    logic          last_cap;
    logic          shift_done;

    // state register with dwell counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dly   <= '0;
        end else begin
            state <= state_n;
            dly   <= (state_n != state) ? '0 : dly + DW'(1);
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (en_i) state_n = ST_CONV;
            ST_CONV:  if (dly == DW'(CONV_CYC - 1)) state_n = ST_SETUP;
            ST_SETUP: if (dly == DW'(SETUP_CYC - 1)) state_n = ST_SHIFT;
            ST_SHIFT: if (shift_done) state_n = ST_REST;
            ST_REST:  if (frame_last) state_n = en_i ? ST_CONV : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnv_o    = (state == ST_CONV);
        shift_on = (state == ST_SHIFT);
    end

    sar_rd_frame_timer #(
        .FRAME_CYC(FRAME_CYC)
    ) u_frame (
        .clk   (clk),
        .rst   (rst),
        .run_i (state != ST_IDLE),
        .last_o(frame_last)
    );

    sar_rd_sclk_gen #(
        .NBITS  (NBITS),
        .SCK_DIV(SCK_DIV),
        .SCK_HI (SCK_HI)
    ) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .active_i  (shift_on),
        .sclk_o    (sclk_o),
        .cap_o     (cap),
        .last_cap_o(last_cap),
        .done_o    (shift_done)
    );

    sar_rd_capture #(
        .NBITS(NBITS)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .last_i (last_cap),
        .sdo_i  (sdo_i),
        .data_o (data_o),
        .valid_o(valid_o)
    );

    // ---------------- checking counters and assertions ----------------
    logic          cnv_d;
    logic          sclk_d;
    logic          rise_seen;
    logic [CW-1:0] chk_hi;
    logic [CW-1:0] chk_fr;
    logic [RW-1:0] chk_rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_d     <= 1'b0;
            sclk_d    <= 1'b0;
            rise_seen <= 1'b0;
            chk_hi    <= '0;
            chk_fr    <= '0;
            chk_rises <= '0;
        end else begin
            cnv_d  <= cnv_o;
            sclk_d <= sclk_o;
            chk_hi <= cnv_o ? chk_hi + CW'(1) : '0;
            if (cnv_o && !cnv_d) begin
                chk_fr    <= CW'(1);
                rise_seen <= 1'b1;
            end else if (chk_fr != {CW{1'b1}}) begin
                chk_fr <= chk_fr + CW'(1);
            end
            if (cnv_o) begin
                chk_rises <= '0;
            end else if (sclk_o && !sclk_d && chk_rises != {RW{1'b1}}) begin
                chk_rises <= chk_rises + RW'(1);
            end
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!cnv_o && !sclk_o && !valid_o)); // R1

    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($fell(cnv_o) && !$past(rst)) |-> (chk_hi == CW'(CONV_CYC))); // R2

    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> !sclk_o); // R4

    AST_BIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (chk_rises == RW'(NBITS))); // R4

    AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (rst)
        (cnv_o && !cnv_d && rise_seen) |-> (chk_fr >= CW'(FRAME_CYC))); // R7
endmodule

// File: tb/sar_rd_ctrl_tb.sv
`timescale 1ns/1ps
module sar_rd_ctrl_tb_top;
    localparam int NB    = 18;
    localparam int CONV  = 142;
    localparam int SETUP = 2;
    localparam int DIV   = 3;
    localparam int HI    = 1;
    localparam int FRAME = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          sdo = 1'b0;
    logic          cnv;
    logic          sclk;
    logic [NB-1:0] data;
    logic          valid;

    sar_rd_ctrl #(
        .NBITS(NB), .CONV_CYC(CONV), .SETUP_CYC(SETUP),
        .SCK_DIV(DIV), .SCK_HI(HI), .FRAME_CYC(FRAME)
    ) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .sdo_i(sdo),
        .cnv_o(cnv), .sclk_o(sclk), .data_o(data), .valid_o(valid)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter model and driver ----------------
    logic [NB-1:0] exp_q[$];
    logic [NB-1:0] dev_word = '0;
    int            dev_idx  = 0;
    int            conv_k   = 0;

    function automatic logic [NB-1:0] pat(input int k);
        case (k)
            0: pat = 18'h3FFFF;
            1: pat = 18'h00000;
            2: pat = 18'h2AAAA;
            3: pat = 18'h15555;
            4: pat = 18'h20000;
            5: pat = 18'h00001;
            default: pat = NB'(k * 32'h0001B3D7) ^ NB'(k << 7);
        endcase
    endfunction

    task automatic drv_push(input logic [NB-1:0] w);
        exp_q.push_back(w);
    endtask

    always @(posedge cnv) begin
        dev_word = pat(conv_k);
        conv_k++;
        drv_push(dev_word);
    end

    always @(negedge cnv) begin
        #1;
        dev_idx = NB - 1;
        sdo = dev_word[dev_idx];
    end

    always @(negedge sclk) begin
        #1;
        if (dev_idx > 0) begin
            dev_idx--;
            sdo = dev_word[dev_idx];
        end
    end

    // ---------------- monitor ----------------
    longint        cyc = 0;
    logic          p_cnv = 0, p_sclk = 0, p_valid = 0;
    logic [NB-1:0] p_data = '0;
    int            hi_run = 0, sclk_hi_run = 0;
    int            setup_cnt = 0;
    bit            waiting = 0;
    int            rises = 0;
    longint        last_sclk_rise = 0;
    longint        last_cnv_rise = 0;
    bit            have_prev = 0;
    int            vcount = 0;
    int            cnv_rises = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            p_cnv = cnv; p_sclk = sclk; p_valid = valid; p_data = data;
            hi_run = 0; sclk_hi_run = 0; waiting = 0; rises = 0; have_prev = 0;
        end else begin
            if (!en) have_prev = 0;
            if (cnv && sclk) chk(0, "R4", "sclk high while start line high", 1, 0);
            // start line
            if (cnv && !p_cnv) begin
                cnv_rises++;
                if (have_prev)
                    chk(cyc - last_cnv_rise == FRAME, "R7", "frame period",
                        cyc - last_cnv_rise, FRAME);
                last_cnv_rise = cyc;
                have_prev = en;
                hi_run = 1;
                rises = 0;
            end else if (cnv) begin
                hi_run++;
            end
            if (!cnv && p_cnv) begin
                chk(hi_run == CONV, "R2", "conversion hold", hi_run, CONV);
                waiting = 1;
                setup_cnt = 0;
            end
            // serial clock
            if (sclk && !p_sclk) begin
                if (waiting) begin
                    chk(setup_cnt == SETUP, "R3", "setup gap", setup_cnt, SETUP);
                    waiting = 0;
                end
                if (rises > 0)
                    chk(cyc - last_sclk_rise == DIV, "R4", "sclk period",
                        cyc - last_sclk_rise, DIV);
                rises++;
                last_sclk_rise = cyc;
                sclk_hi_run = 1;
            end else if (sclk) begin
                sclk_hi_run++;
            end
            if (!sclk && p_sclk)
                chk(sclk_hi_run == HI, "R4", "sclk high width", sclk_hi_run, HI);
            if (waiting && !cnv && !sclk) setup_cnt++;
            // results
            if (valid) begin
                vcount++;
                chk(!p_valid, "R6", "valid wider than one cycle", 2, 1);
                chk(rises == NB, "R4", "sclk rises per frame", rises, NB);
                chk(cyc - last_sclk_rise == 1, "R6", "valid delay after last capture",
                    cyc - last_sclk_rise, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected sample", data, -1);
                end else begin
                    logic [NB-1:0] e;
                    e = exp_q.pop_front();
                    chk(data == e, "R5", "sample word", data, e);
                end
            end else if (data != p_data) begin
                chk(0, "R6", "word changed without valid", data, p_data);
            end
            p_cnv = cnv; p_sclk = sclk; p_valid = valid; p_data = data;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_valids(input int n);
        while (vcount < n) @(negedge clk);
    endtask

    task automatic check_quiet(input string req);
        chk(cnv == 0,   req, "start line low", cnv, 0);
        chk(sclk == 0,  req, "sclk low", sclk, 0);
        chk(valid == 0, req, "valid low", valid, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_quiet("R1");
        chk(data == 0, "R1", "word cleared", data, 0);
        rst = 0;
        repeat (5) @(negedge clk);
        check_quiet("R8");
        // start from idle
        en = 1;
        @(negedge clk);
        chk(cnv == 1, "R2", "start line one cycle after enable", cnv, 1);
        wait_valids(12);
        // reset in the middle of a shift
        @(negedge cnv);
        repeat (20) @(negedge clk);
        chk(sclk == 1 || sclk == 0, "R4", "in shift phase", 0, 0);
        rst = 1;
        @(negedge clk);
        exp_q.delete();
        @(negedge clk);
        check_quiet("R1");
        chk(data == 0, "R1", "word cleared by mid-run reset", data, 0);
        rst = 0;
        begin
            int v0;
            v0 = vcount;
            wait_valids(v0 + 6);
        end
        // drop enable inside a conversion hold
        @(posedge cnv);
        repeat (3) @(negedge clk);
        begin
            int r0, v0;
            en = 0;
            r0 = cnv_rises;
            v0 = vcount;
            repeat (700) @(negedge clk);
            chk(cnv_rises == r0, "R8", "no new conversion after disable", cnv_rises, r0);
            chk(vcount == v0 + 1, "R8", "frame in progress delivered", vcount, v0 + 1);
            chk(exp_q.size() == 0, "R8", "no pending sample", exp_q.size(), 0);
            check_quiet("R8");
        end
        // restart
        en = 1;
        @(negedge clk);
        chk(cnv == 1, "R2", "restart after re-enable", cnv, 1);
        begin
            int v0;
            v0 = vcount;
            wait_valids(v0 + 3);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule